// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the host-facing register port of a CMOS real-time clock. A host reaches 128 bytes through two byte-wide addresses. A write to the even address selects a byte by loading a 7-bit pointer. An access to the odd address then reads or writes the selected byte. Most bytes are plain storage. Four control and status bytes have their own rules: a read-only update-in-progress bit, divider hold and set-mode freezes, interrupt flags that clear when read, and an interrupt that is raised at once when a pending flag becomes enabled.

The block holds a sub-second divider fed by a reference tick. It tells the counting logic when a second ends (`sec_tick`) and when the time bytes must stay still (`time_freeze`). Periodic and alarm events from neighbouring logic arrive as one-cycle strobes and land in the flag byte. A device-reset strobe gives the soft-reset behaviour, which keeps most state. The active-low `rst_n` is the power-on reset.

Bit layout used throughout:
- Control byte A (index 0x0A): bit 7 is update-in-progress, bits 6:4 select the divider, bits 3:0 give the rate.
- Control byte B (index 0x0B): bit 7 is set mode, bit 6 enables periodic interrupts, bit 5 enables alarm interrupts, bit 4 enables update-ended interrupts, bit 3 enables the square wave.
- Flag byte C (index 0x0C): bit 7 is the interrupt flag, bit 6 is periodic, bit 5 is alarm, bit 4 is update-ended.
- Status byte D (index 0x0D): constant.
- Index 0x0F is the shutdown byte.

Top module: `rtcp_port`

## Requirements
- R1: A write to the even address (`bus_addr`=0) loads `bus_wdata[6:0]` as the index, ignoring bit 7. A read of the even address returns 0xFF. Read data appears on `bus_rdata` one cycle after the `bus_rd` cycle and holds until the next read.
- R2: Every index other than 0x0A–0x0D and 0x0F behaves as plain read/write byte storage.
- R3: A read of index 0x0C returns the flag byte, then clears it to 0x00, so `irq` is low on the following cycle.
- R4: Writes to indices 0x0C and 0x0D have no effect. Index 0x0D always reads 0x80.
- R5: Bit 7 of index 0x0A cannot be written. A read returns the live update-in-progress state in bit 7 and the stored bits 6:0.
- R6: With the divider running (A bits 6:4 ≤ 2) and set mode off, update-in-progress reads 1 exactly while the divider is within the last UIP_TICKS reference ticks of a second. A second ends every TICKS_PER_SEC ticks.
- R7: A write to index 0x0B with bit 7 set stores bit 4 as 0, clears update-in-progress, and raises `time_freeze`. While set mode is on, no update-ended flag and no `sec_tick` are produced, and update-in-progress reads 0.
- R8: After a write to index 0x0B, flag bit 7 and `irq` go to 1 if any of B bits 6:4 matches a set bit among C bits 6:4. Otherwise they go to 0.
- R9: A bits 6:5 = 11 hold the divider and raise `time_freeze`. After a release to a running value, the first `sec_tick` follows after TICKS_PER_SEC/2 reference ticks.
- R10: A second end (outside set mode), `evt_periodic` and `evt_alarm` set C bits 4, 6 and 5. A newly set flag whose enable in B bits 6:4 is on sets C bit 7, and `irq` follows C bit 7.
- R11: After power-on reset, A=0x26, B=0x02, C=0x00, D=0x80, and `irq` is low.
- R12: A `dev_rst` pulse clears B bits 6, 5 and 3 and all of C. It clears index 0x0F unless that byte holds 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 1 | Address bit 0: 0 = index, 1 = data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| dev_rst | input | 1 | Soft device-reset strobe |
| ref_tick | input | 1 | Reference divider tick |
| evt_periodic | input | 1 | Periodic event strobe |
| evt_alarm | input | 1 | Alarm event strobe |
| sec_tick | output | 1 | One-cycle pulse at each second end, outside set mode |
| time_freeze | output | 1 | Time bytes must not advance |

## Verification
The bench probes update-in-progress on the last tick before the window and the first tick inside it. A design with an off-by-one window would flip bit 7 one tick early or late. It releases a held divider and counts ticks up to the first second end. A design that restarts from zero instead of half a second would pulse after twice as many ticks. It enables an interrupt over an already-pending flag and over a non-matching flag. A design that ignores B writes for the interrupt decision would leave `irq` wrong in one of the two cases. Device reset is run with the shutdown byte both at 0xFE and at another value, to catch an unconditional clear or a missing clear.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int IDX_W = 7;

  localparam logic [IDX_W-1:0] IDX_CTRL_A = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_CTRL_B = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_FLAGS  = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_STATUS = 7'h0D;
  localparam logic [IDX_W-1:0] IDX_SHUT   = 7'h0F;

  localparam logic [7:0] CTRL_A_RST   = 8'h26;
  localparam logic [7:0] CTRL_B_RST   = 8'h02;
  localparam logic [7:0] STATUS_VAL   = 8'h80;
  localparam logic [7:0] SOFT_B_CLEAR = 8'h68;
  localparam logic [7:0] SHUT_KEEP    = 8'hFE;
  localparam logic [7:0] EVEN_RD_VAL  = 8'hFF;
endpackage

// File: rtl/rtcp_divider.sv
module rtcp_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic hold,
  input  logic run,
  output logic boundary,
  output logic late_window
);
  localparam int CW   = $clog2(TICKS_PER_SEC);
  localparam int HALF = TICKS_PER_SEC / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end      = (cnt_q == CW'(TICKS_PER_SEC - 1));
  assign boundary    = ref_tick && run && at_end;
  assign late_window = run && (cnt_q >= CW'(TICKS_PER_SEC - UIP_TICKS));

  always_comb begin
    cnt_d = cnt_q;
    if (hold) begin
      cnt_d = CW'(HALF);
    end else if (ref_tick && run) begin
      cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_hold_loads_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == CW'(HALF)));

  assert_second_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && run && at_end && !hold) |=> (cnt_q == '0));
endmodule

// File: rtl/rtcp_ctrl.sv
module rtcp_ctrl
  import rtcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  input  logic             evt_periodic,
  input  logic             evt_alarm,
  input  logic             boundary,
  input  logic             late_window,
  output logic [7:0]       a_q,
  output logic [7:0]       b_q,
  output logic [7:0]       c_q,
  output logic [7:0]       rd_a,
  output logic             hold,
  output logic             run,
  output logic             irq,
  output logic             sec_tick,
  output logic             freeze
);
  logic [7:0] a_d, b_d, c_d;
  logic [2:0] new_flags, fresh;
  logic       uip_now, sec_q;
  logic       wr_a, wr_b, rd_a_en, rd_c, any_evt;

  assign hold      = (a_q[6:5] == 2'b11);
  assign run       = (a_q[6:4] <= 3'd2);
  assign uip_now   = run && !b_q[7] && late_window;
  assign rd_a      = {uip_now, a_q[6:0]};
  assign irq       = c_q[7];
  assign sec_tick  = sec_q;
  assign freeze    = b_q[7] || hold;
  assign wr_a      = wr_en && (idx == IDX_CTRL_A);
  assign wr_b      = wr_en && (idx == IDX_CTRL_B);
  assign rd_a_en   = rd_en && (idx == IDX_CTRL_A);
  assign rd_c      = rd_en && (idx == IDX_FLAGS);
  // flag order matches C bits 6:4 = periodic, alarm, update-ended
  assign new_flags = {evt_periodic, evt_alarm, boundary && !b_q[7]};
  assign any_evt   = evt_periodic || evt_alarm || boundary;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    c_d   = c_q;
    fresh = '0;
    if (dev_rst) begin
      b_d = b_q & ~SOFT_B_CLEAR;
      c_d = '0;
    end else begin
      if (wr_a) begin
        a_d = {a_q[7], wdata[6:0]};
        if (wdata[6:5] == 2'b11 || hold) a_d[7] = 1'b0;
      end
      if (wr_b) begin
        b_d = wdata;
        if (wdata[7]) begin
          b_d[4] = 1'b0;
          a_d[7] = 1'b0;
        end
        c_d[7] = |(b_d[6:4] & c_q[6:4]);
      end
      if (rd_a_en) a_d[7] = uip_now;
      if (rd_c)    c_d    = '0;
      fresh    = new_flags & ~c_d[6:4];
      c_d[6:4] = c_d[6:4] | new_flags;
      if (|(fresh & b_d[6:4])) c_d[7] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= CTRL_A_RST;
      b_q   <= CTRL_B_RST;
      c_q   <= '0;
      sec_q <= 1'b0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      c_q   <= c_d;
      sec_q <= boundary && !b_q[7];
    end
  end

  assert_flags_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !dev_rst && !any_evt) |=> (c_q == 8'h00));

  assert_flag_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IDX_FLAGS || idx == IDX_STATUS) && !dev_rst && !any_evt && !rd_en)
      |=> $stable(c_q));

  assert_set_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[7] && !dev_rst) |=> (!b_q[4] && !a_q[7]));

  assert_enable_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && !dev_rst && !any_evt && !rd_en) |=> (irq == |(b_q[6:4] & c_q[6:4])));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> (c_q == 8'h00 && (b_q & SOFT_B_CLEAR) == 8'h00));
endmodule

// File: rtl/rtcp_store.sv
module rtcp_store
  import rtcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] shut_q, shut_d;
  logic       plain_wr;

  assign plain_wr = wr_en && (idx != IDX_SHUT);
  assign rdata    = (idx == IDX_SHUT) ? shut_q : mem[idx];

  always_comb begin
    shut_d = shut_q;
    if (dev_rst) begin
      if (shut_q != SHUT_KEEP) shut_d = '0;
    end else if (wr_en && idx == IDX_SHUT) begin
      shut_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shut_q <= '0;
    else        shut_q <= shut_d;
  end

  always_ff @(posedge clk) begin
    if (plain_wr) mem[idx] <= wdata;
  end

  assert_shut_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst && shut_q == SHUT_KEEP) |=> (shut_q == SHUT_KEEP));
endmodule

// File: rtl/rtcp_port.sv
module rtcp_port
  import rtcp_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       dev_rst,
  input  logic       ref_tick,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  output logic       sec_tick,
  output logic       time_freeze
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       rdata_q, rdata_d, rd_mux;
  logic [7:0]       a_q, b_q, c_q, rd_a, store_rd;
  logic             data_wr, data_rd, is_ctrl;
  logic             hold, run, boundary, late_window;

  assign data_wr = bus_wr && bus_addr;
  assign data_rd = bus_rd && bus_addr;
  assign is_ctrl = (idx_q >= IDX_CTRL_A) && (idx_q <= IDX_STATUS);

  rtcp_divider #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick   (ref_tick),
    .hold       (hold),
    .run        (run),
    .boundary   (boundary),
    .late_window(late_window)
  );

  rtcp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_rst     (dev_rst),
    .wr_en       (data_wr),
    .rd_en       (data_rd),
    .idx         (idx_q),
    .wdata       (bus_wdata),
    .evt_periodic(evt_periodic),
    .evt_alarm   (evt_alarm),
    .boundary    (boundary),
    .late_window (late_window),
    .a_q         (a_q),
    .b_q         (b_q),
    .c_q         (c_q),
    .rd_a        (rd_a),
    .hold        (hold),
    .run         (run),
    .irq         (irq),
    .sec_tick    (sec_tick),
    .freeze      (time_freeze)
  );

  rtcp_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .dev_rst(dev_rst),
    .wr_en  (data_wr && !is_ctrl),
    .idx    (idx_q),
    .wdata  (bus_wdata),
    .rdata  (store_rd)
  );

  always_comb begin
    unique case (idx_q)
      IDX_CTRL_A: rd_mux = rd_a;
      IDX_CTRL_B: rd_mux = b_q;
      IDX_FLAGS:  rd_mux = c_q;
      IDX_STATUS: rd_mux = STATUS_VAL;
      default:    rd_mux = store_rd;
    endcase
  end

  always_comb begin
    idx_d   = idx_q;
    rdata_d = rdata_q;
    if (bus_wr && !bus_addr) idx_d = bus_wdata[IDX_W-1:0];
    if (bus_rd) rdata_d = bus_addr ? rd_mux : EVEN_RD_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      idx_q   <= idx_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  assert_even_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr) |=> (bus_rdata == EVEN_RD_VAL));

  assert_status_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx_q == IDX_STATUS) |=> (bus_rdata == STATUS_VAL));
endmodule

// File: tb/tb_rtcp_port.sv
module tb_rtcp_port;
  localparam int TPS = 32;
  localparam int UIPT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, sec_tick, time_freeze;
  logic       dev_rst = 1'b0, ref_tick = 1'b0, evt_periodic = 1'b0, evt_alarm = 1'b0;

  int checks = 0, fails = 0, cyc = 0, sec_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtcp_port #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dev_rst(dev_rst),
    .ref_tick(ref_tick), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
    .sec_tick(sec_tick), .time_freeze(time_freeze));

  // behavioural reference model
  int m_idx, m_a, m_b, m_c, m_shut, m_cnt, m_rdata, m_sec;
  int m_mem [128];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_a = 'h26; m_b = 'h02; m_c = 0; m_shut = 0;
      m_cnt = 0; m_rdata = 0; m_sec = 0;
    end else begin
      automatic bit running = ((m_a >> 4) & 7) <= 2;
      automatic bit held = ((m_a >> 5) & 3) == 3;
      automatic bit setm = (m_b & 'h80) != 0;
      automatic bit bnd = ref_tick && running && (m_cnt == TPS - 1);
      automatic bit uip = running && !setm && (m_cnt >= TPS - UIPT);
      automatic int na = m_a, nb = m_b, nc = m_c, flags = 0;
      automatic int special = (m_idx >= 'h0A && m_idx <= 'h0D);
      if (bus_rd) begin
        if (!bus_addr) m_rdata = 'hFF;
        else case (m_idx)
          'h0A: m_rdata = (m_a & 'h7F) | (uip ? 'h80 : 0);
          'h0B: m_rdata = m_b;
          'h0C: m_rdata = m_c;
          'h0D: m_rdata = 'h80;
          'h0F: m_rdata = m_shut;
          default: m_rdata = m_mem[m_idx];
        endcase
      end
      if (dev_rst) begin
        nb = m_b & ~'h68; nc = 0;
        if (m_shut != 'hFE) m_shut = 0;
      end else begin
        if (bus_wr && bus_addr && m_idx == 'h0A) begin
          na = (m_a & 'h80) | (bus_wdata & 'h7F);
          if (((bus_wdata >> 5) & 3) == 3 || held) na = na & 'h7F;
        end
        if (bus_wr && bus_addr && m_idx == 'h0B) begin
          nb = bus_wdata;
          if (bus_wdata & 'h80) begin nb = nb & ~'h10; na = na & 'h7F; end
          nc = (nb & m_c & 'h70) ? (m_c | 'h80) : (m_c & 'h7F);
        end
        if (bus_rd && bus_addr && m_idx == 'h0A) na = (na & 'h7F) | (uip ? 'h80 : 0);
        if (bus_rd && bus_addr && m_idx == 'h0C) nc = 0;
        if (evt_periodic) flags |= 'h40;
        if (evt_alarm) flags |= 'h20;
        if (bnd && !setm) flags |= 'h10;
        if (flags & ~nc & nb) nc |= 'h80;
        nc |= flags;
        if (bus_wr && bus_addr && m_idx == 'h0F) m_shut = bus_wdata;
      end
      if (bus_wr && bus_addr && !special && m_idx != 'h0F) m_mem[m_idx] = bus_wdata;
      if (bus_wr && !bus_addr) m_idx = bus_wdata & 'h7F;
      m_sec = bnd && !setm;
      if (held) m_cnt = TPS / 2;
      else if (ref_tick && running) m_cnt = (m_cnt == TPS - 1) ? 0 : m_cnt + 1;
      m_a = na; m_b = nb; m_c = nc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk("R10 irq vs model", int'(irq), (m_c >> 7) & 1);
      chk("R9 sec_tick vs model", int'(sec_tick), m_sec);
      chk("R7 time_freeze vs model", int'(time_freeze),
          ((m_b >> 7) & 1) | int'(((m_a >> 5) & 3) == 3));
      chk("R2 rdata vs model", int'(bus_rdata), m_rdata);
    end
  end

  task automatic put(input bit a, input int d);
    @(negedge clk); bus_addr = a; bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic wreg(input int i, input int d);
    put(1'b0, i); put(1'b1, d);
  endtask

  task automatic rd_chk(input bit a, input int i, input int exp, input string tag);
    if (a) put(1'b0, i);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      if (sec_tick) sec_seen++;
    end
  endtask

  task automatic pulse_evt(input bit per, input bit alm);
    @(negedge clk); evt_periodic = per; evt_alarm = alm;
    @(negedge clk); evt_periodic = 1'b0; evt_alarm = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= 100000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 irq after reset", int'(irq), 0);
    rd_chk(1, 'h0A, 'h26, "R11 A reset");
    rd_chk(1, 'h0B, 'h02, "R11 B reset");
    rd_chk(1, 'h0C, 'h00, "R11 C reset");
    rd_chk(1, 'h0D, 'h80, "R11 D reset");
    rd_chk(0, 0, 'hFF, "R1 even read");
    // R2 / R1 storage and index
    wreg('h20, 'h5A); wreg('h7F, 'hC3); wreg('h00, 'h59);
    rd_chk(1, 'hA0, 'h5A, "R1 index bit7 ignored");
    rd_chk(1, 'h7F, 'hC3, "R2 top index");
    rd_chk(1, 'h00, 'h59, "R2 time byte storage");
    // R4 read-only C and D
    wreg('h0C, 'hFF); wreg('h0D, 'h00);
    rd_chk(1, 'h0C, 'h00, "R4 C write ignored");
    rd_chk(1, 'h0D, 'h80, "R4 D write ignored");
    // R5 UIP not writable
    wreg('h0A, 'hA6);
    rd_chk(1, 'h0A, 'h26, "R5 UIP write ignored");
    // R6 window edges
    tick(TPS - UIPT - 1);
    rd_chk(1, 'h0A, 'h26, "R6 before window");
    tick(1);
    rd_chk(1, 'h0A, 'hA6, "R6 first window tick");
    s0 = sec_seen;
    tick(UIPT - 1);
    rd_chk(1, 'h0A, 'hA6, "R6 last window tick");
    tick(1);
    chk("R6 second end pulse", sec_seen - s0, 1);
    rd_chk(1, 'h0C, 'h10, "R10 update flag");
    rd_chk(1, 'h0A, 'h26, "R6 window left");
    // R10 / R3 periodic interrupt
    wreg('h0B, 'h42);
    pulse_evt(1, 0);
    chk("R10 irq on enabled flag", int'(irq), 1);
    rd_chk(1, 'h0C, 'hC0, "R3 C read value");
    chk("R3 irq low after read", int'(irq), 0);
    rd_chk(1, 'h0C, 'h00, "R3 C cleared");
    // R8 enable over pending flag
    wreg('h0B, 'h02);
    pulse_evt(0, 1);
    chk("R10 disabled flag no irq", int'(irq), 0);
    wreg('h0B, 'h22);
    chk("R8 immediate irq", int'(irq), 1);
    rd_chk(1, 'h0C, 'hA0, "R8 IRQF set");
    pulse_evt(0, 1);
    wreg('h0B, 'h42);
    chk("R8 no match irq low", int'(irq), 0);
    rd_chk(1, 'h0C, 'h20, "R8 IRQF cleared");
    // R7 set mode
    wreg('h0B, 'h92);
    rd_chk(1, 'h0B, 'h82, "R7 UIE forced off");
    chk("R7 freeze in set mode", int'(time_freeze), 1);
    tick(TPS - UIPT);
    rd_chk(1, 'h0A, 'h26, "R7 no UIP in set mode");
    s0 = sec_seen;
    tick(UIPT);
    chk("R7 no second pulse", sec_seen - s0, 0);
    rd_chk(1, 'h0C, 'h00, "R7 no update flag");
    wreg('h0B, 'h02);
    chk("R7 freeze released", int'(time_freeze), 0);
    // R9 divider hold and half-second restart
    wreg('h0A, 'h66);
    chk("R9 freeze in divider hold", int'(time_freeze), 1);
    s0 = sec_seen;
    tick(40);
    chk("R9 held no pulse", sec_seen - s0, 0);
    rd_chk(1, 'h0A, 'h66, "R9 held A");
    wreg('h0A, 'h26);
    tick(TPS / 2 - 1);
    chk("R9 none before half", sec_seen - s0, 0);
    tick(1);
    chk("R9 pulse at half", sec_seen - s0, 1);
    rd_chk(1, 'h0C, 'h10, "R9 update flag after restart");
    // R12 device reset
    wreg('h0B, 'h7A);
    pulse_evt(1, 0);
    chk("R10 irq before soft reset", int'(irq), 1);
    wreg('h0F, 'hFE);
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    chk("R12 irq low", int'(irq), 0);
    rd_chk(1, 'h0B, 'h12, "R12 B masked");
    rd_chk(1, 'h0C, 'h00, "R12 C cleared");
    rd_chk(1, 'h0F, 'hFE, "R12 shutdown kept");
    wreg('h0F, 'h33);
    @(negedge clk); dev_rst = 1'b1;
    @(negedge clk); dev_rst = 1'b0;
    rd_chk(1, 'h0F, 'h00, "R12 shutdown cleared");
    rd_chk(1, 'h20, 'h5A, "R2 storage survives soft reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule